// File: doc/BRIEF.md
# Segment Relocation and Bounds Unit

This block turns a program-relative offset into a physical address using one relocation base and one segment size. Each request arrives with a valid strobe. One cycle later the block gives one of two results. Either it raises a memory request carrying base plus offset, or it raises a protection fault and leaves the request low. An offset is legal only when it is below the segment size. The sum must also fit in the physical address width. The size check uses the raw offset, before any addition, so a large base cannot wrap around and hide a violation.

The two registers can be changed only in supervisor mode. Single-field writes go through a configuration port. A whole-pair restore goes through a context port and is used when the running program changes. The current pair is always visible on two output ports, so it can be saved. A write tried in user mode changes nothing and produces a one-cycle privilege-fault pulse.

Top module: `seg_prot_unit`

## Requirements
- R1: After synchronous reset the base and the size both read zero, and `mem_valid`, `prot_fault` and `priv_fault` are low. With size zero, every request faults.
- R2: A request whose offset is below the size, and whose sum fits, gives `mem_valid` high on the cycle after it is sampled, with `mem_addr` equal to base plus offset.
- R3: A request whose offset is greater than or equal to the size gives `prot_fault` high and `mem_valid` low on the cycle after it is sampled.
- R4: A request whose base plus offset carries out of the `PA_W`-bit physical space faults in the same way as R3, even when the offset is below the size.
- R5: In supervisor mode (`supervisor`=1), `cfg_wr_en` writes `cfg_wdata` into the base when `cfg_sel`=0. When `cfg_sel`=1 it writes the low `LEN_W` bits of `cfg_wdata` into the size. The new value shows on `cur_base` or `cur_len` after that clock edge.
- R6: A `cfg_wr_en` or `ctx_load` raised while `supervisor`=0 leaves both registers unchanged and gives `priv_fault` high for exactly one cycle after that edge.
- R7: `ctx_load` in supervisor mode loads `ctx_base` and `ctx_len` together. If `cfg_wr_en` is raised in the same cycle, `ctx_load` takes priority.
- R8: A request sampled in the same cycle as an accepted register write is checked and relocated with the pair that held before that write.
- R9: A cycle with `req_valid` low gives `mem_valid` and `prot_fault` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_offset | input | OFF_W | Program-relative offset |
| supervisor | input | 1 | 1 = privileged mode |
| cfg_wr_en | input | 1 | Single-register write strobe |
| cfg_sel | input | 1 | 0 = base, 1 = size |
| cfg_wdata | input | PA_W | Write data |
| ctx_load | input | 1 | Whole-pair restore strobe |
| ctx_base | input | PA_W | Base to restore |
| ctx_len | input | LEN_W | Size to restore |
| cur_base | output | PA_W | Current base, for saving |
| cur_len | output | LEN_W | Current size, for saving |
| mem_valid | output | 1 | Downstream memory request |
| mem_addr | output | PA_W | Physical address |
| prot_fault | output | 1 | Bounds violation pulse |
| priv_fault | output | 1 | Rejected privileged write pulse |

## Verification
An accepted register write and a translation can happen in the same cycle. The bench drives a request together with a supervisor write of the base or of the pair. It expects the address to be formed from the pair that held before the edge, and the new value to appear on `cur_base` on the same result cycle. A rejected user write is also issued alongside a faulting request. Both fault pulses must then rise together while the registers stay unchanged.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int DEF_OFF_W = 16;
    localparam int DEF_PA_W  = 20;

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_SIZE = 1'b1
    } cfg_sel_e;

    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_PASS  = 2'd1,
        RES_FAULT = 2'd2
    } xlate_res_e;

    function automatic xlate_res_e classify(input logic valid, input logic legal);
        if (!valid)     return RES_IDLE;
        else if (legal) return RES_PASS;
        else            return RES_FAULT;
    endfunction
endpackage

// File: rtl/seg_regs.sv
module seg_regs
    import seg_pkg::*;
#(
    parameter int PA_W  = DEF_PA_W,
    parameter int LEN_W = DEF_OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supervisor,
    input  logic             cfg_wr_en,
    input  cfg_sel_e         cfg_sel,
    input  logic [PA_W-1:0]  cfg_wdata,
    input  logic             ctx_load,
    input  logic [PA_W-1:0]  ctx_base,
    input  logic [LEN_W-1:0] ctx_len,
    output logic [PA_W-1:0]  base_q,
    output logic [LEN_W-1:0] len_q,
    output logic             reject
);
    logic attempt;
    assign attempt = cfg_wr_en | ctx_load;
    assign reject  = attempt & ~supervisor;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
        end else if (supervisor) begin
            if (ctx_load) begin
                base_q <= ctx_base;
                len_q  <= ctx_len;
            end else if (cfg_wr_en) begin
                if (cfg_sel == SEL_BASE) base_q <= cfg_wdata;
                else                     len_q  <= cfg_wdata[LEN_W-1:0];
            end
        end
    end

    assert_user_hold_R6: assert property (@(posedge clk) disable iff (rst)
        reject |=> ($stable(base_q) && $stable(len_q)));

    assert_ctx_prio_R7: assert property (@(posedge clk) disable iff (rst)
        (supervisor && ctx_load) |=> (base_q == $past(ctx_base) && len_q == $past(ctx_len)));
endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    parameter int LEN_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [PA_W-1:0]  base,
    input  logic [LEN_W-1:0] len,
    output logic             legal,
    output logic [PA_W-1:0]  phys
);
    localparam int SUM_W = PA_W + 1;

    logic [SUM_W-1:0] sum;
    logic             below;

    assign below = {1'b0, offset} < len;
    assign sum   = {1'b0, base} + {{(SUM_W-OFF_W){1'b0}}, offset};
    assign phys  = sum[PA_W-1:0];
    assign legal = below & ~sum[PA_W];
endmodule

// File: rtl/seg_prot_unit.sv
module seg_prot_unit
    import seg_pkg::*;
#(
    parameter int OFF_W = DEF_OFF_W,
    parameter int PA_W  = DEF_PA_W,
    parameter int LEN_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_offset,
    input  logic             supervisor,
    input  logic             cfg_wr_en,
    input  logic             cfg_sel,
    input  logic [PA_W-1:0]  cfg_wdata,
    input  logic             ctx_load,
    input  logic [PA_W-1:0]  ctx_base,
    input  logic [LEN_W-1:0] ctx_len,
    output logic [PA_W-1:0]  cur_base,
    output logic [LEN_W-1:0] cur_len,
    output logic             mem_valid,
    output logic [PA_W-1:0]  mem_addr,
    output logic             prot_fault,
    output logic             priv_fault
);
    logic             reject;
    logic             legal;
    logic [PA_W-1:0]  phys;
    xlate_res_e       res_q;

    seg_regs #(.PA_W(PA_W), .LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .supervisor (supervisor),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_sel    (cfg_sel_e'(cfg_sel)),
        .cfg_wdata  (cfg_wdata),
        .ctx_load   (ctx_load),
        .ctx_base   (ctx_base),
        .ctx_len    (ctx_len),
        .base_q     (cur_base),
        .len_q      (cur_len),
        .reject     (reject)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)) u_check (
        .offset (req_offset),
        .base   (cur_base),
        .len    (cur_len),
        .legal  (legal),
        .phys   (phys)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q      <= RES_IDLE;
            mem_addr   <= '0;
            priv_fault <= 1'b0;
        end else begin
            res_q      <= classify(req_valid, legal);
            mem_addr   <= (req_valid && legal) ? phys : '0;
            priv_fault <= reject;
        end
    end

    assign mem_valid  = (res_q == RES_PASS);
    assign prot_fault = (res_q == RES_FAULT);

    assert_one_result_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && prot_fault));

    assert_limit_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ({1'b0, req_offset} >= cur_len)) |=> (prot_fault && !mem_valid));

    assert_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ({1'b0, req_offset} < cur_len) &&
         (({1'b0, cur_base} + {{(PA_W+1-OFF_W){1'b0}}, req_offset}) < {1'b1, {PA_W{1'b0}}}))
        |=> (mem_valid && mem_addr == PA_W'($past(cur_base) + {{(PA_W-OFF_W){1'b0}}, $past(req_offset)})));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_valid && !prot_fault));

    assert_priv_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (!supervisor && (cfg_wr_en || ctx_load)) |=> priv_fault);
endmodule

// File: tb/tb_seg_prot_unit.sv
module tb_seg_prot_unit;
    localparam int OFF_W = 16;
    localparam int PA_W  = 20;
    localparam int LEN_W = OFF_W + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [OFF_W-1:0] req_offset = '0;
    logic             supervisor = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [PA_W-1:0]  cfg_wdata = '0;
    logic             ctx_load = 1'b0;
    logic [PA_W-1:0]  ctx_base = '0;
    logic [LEN_W-1:0] ctx_len = '0;
    logic [PA_W-1:0]  cur_base;
    logic [LEN_W-1:0] cur_len;
    logic             mem_valid;
    logic [PA_W-1:0]  mem_addr;
    logic             prot_fault;
    logic             priv_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic            mv;
        logic            pf;
        logic            vf;
        logic [PA_W-1:0] addr;
        logic [PA_W-1:0] base;
        logic [LEN_W-1:0] len;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    logic [PA_W-1:0]  m_base = '0;
    logic [LEN_W-1:0] m_len  = '0;

    always #2 clk = ~clk;

    seg_prot_unit #(.OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_offset(req_offset),
        .supervisor(supervisor), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctx_load(ctx_load), .ctx_base(ctx_base),
        .ctx_len(ctx_len), .cur_base(cur_base), .cur_len(cur_len),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .prot_fault(prot_fault),
        .priv_fault(priv_fault)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // driver: one stimulus per cycle, expected outcome pushed to scoreboard
    task automatic step(input logic rv, input logic [OFF_W-1:0] off, input logic sup,
                        input logic we, input logic sel, input logic [PA_W-1:0] wd,
                        input logic cl, input logic [PA_W-1:0] cb, input logic [LEN_W-1:0] cln,
                        input string tag);
        exp_t e;
        logic [PA_W:0] sum;
        logic legal;
        @(negedge clk);
        req_valid = rv; req_offset = off; supervisor = sup; cfg_wr_en = we;
        cfg_sel = sel; cfg_wdata = wd; ctx_load = cl; ctx_base = cb; ctx_len = cln;
        sum = {1'b0, m_base} + {{(PA_W+1-OFF_W){1'b0}}, off};
        legal = ({1'b0, off} < m_len) && !sum[PA_W];
        e.mv = rv && legal;
        e.pf = rv && !legal;
        e.addr = (rv && legal) ? sum[PA_W-1:0] : '0;
        e.vf = (we || cl) && !sup;
        if (sup && cl) begin
            m_base = cb; m_len = cln;
        end else if (sup && we) begin
            if (!sel) m_base = wd; else m_len = wd[LEN_W-1:0];
        end
        e.base = m_base;
        e.len = m_len;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare one result per cycle, after the edge
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "mem_valid", 32'(mem_valid), 32'(e.mv));
            check(e.tag, "prot_fault", 32'(prot_fault), 32'(e.pf));
            check(e.tag, "priv_fault", 32'(priv_fault), 32'(e.vf));
            if (e.mv) check(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
            check(e.tag, "cur_base", 32'(cur_base), 32'(e.base));
            check(e.tag, "cur_len", 32'(cur_len), 32'(e.len));
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "cur_base", 32'(cur_base), 32'h0);
        check("R1", "cur_len", 32'(cur_len), 32'h0);
        check("R1", "mem_valid", 32'(mem_valid), 32'h0);
        check("R1", "prot_fault", 32'(prot_fault), 32'h0);
        check("R1", "priv_fault", 32'(priv_fault), 32'h0);
        step(1, 16'h0, 0, 0, 0, '0, 0, '0, '0, "R1");        // size zero faults
        // R5 supervisor writes
        step(0, 16'h0, 1, 1, 0, 20'h01000, 0, '0, '0, "R5");
        step(0, 16'h0, 1, 1, 1, 20'h00100, 0, '0, '0, "R5");
        // R2 legal requests
        step(1, 16'h0000, 0, 0, 0, '0, 0, '0, '0, "R2");
        step(1, 16'h00FF, 0, 0, 0, '0, 0, '0, '0, "R2");
        step(1, 16'h0042, 0, 0, 0, '0, 0, '0, '0, "R2");
        // R3 out of bounds
        step(1, 16'h0100, 0, 0, 0, '0, 0, '0, '0, "R3");
        step(1, 16'hFFFF, 0, 0, 0, '0, 0, '0, '0, "R3");
        // R9 idle
        step(0, 16'h0010, 0, 0, 0, '0, 0, '0, '0, "R9");
        // R6 user-mode writes rejected, one alongside a faulting request
        step(0, 16'h0, 0, 1, 0, 20'hABCDE, 0, '0, '0, "R6");
        step(1, 16'h0200, 0, 0, 0, '0, 1, 20'h55555, 17'h1FFFF, "R6");
        step(1, 16'h0010, 0, 0, 0, '0, 0, '0, '0, "R6");
        // R7 context restore wins over single write
        step(0, 16'h0, 1, 1, 1, 20'h00003, 1, 20'hFFF00, 17'h10000, "R7");
        step(1, 16'h00FF, 0, 0, 0, '0, 0, '0, '0, "R7");
        // R4 carry out of physical space
        step(1, 16'h0100, 0, 0, 0, '0, 0, '0, '0, "R4");
        step(1, 16'hFFFF, 0, 0, 0, '0, 0, '0, '0, "R4");
        // R8 request with concurrent accepted write uses old pair
        step(1, 16'h0005, 1, 0, 0, '0, 1, 20'h20000, 17'h00040, "R8");
        step(1, 16'h0005, 1, 1, 0, 20'h30000, 0, '0, '0, "R8");
        step(1, 16'h0040, 0, 0, 0, '0, 0, '0, '0, "R8");
        step(1, 16'h003F, 0, 0, 0, '0, 0, '0, '0, "R2");
        step(0, 16'h0, 0, 0, 0, '0, 0, '0, '0, "R9");
        repeat (3) @(negedge clk);
        check("R2", "scoreboard empty", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule